// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Port

This block receives the programming word of a frequency synthesizer over three serial lines: a data line, a serial clock and an enable. While enable is high, every rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When enable falls, a word with exactly the configured number of bits is accepted. A word of any other length is dropped.

An accepted word is not applied at once. It waits in a pending holding register until the programmable divider marks the end of one of its cycles with a one-cycle pulse. Only then does the word reach the active control fields. Ratio changes therefore take effect on a divider cycle boundary, and tuning moves smoothly. If a second word is accepted before that pulse, it replaces the first one.

The three serial lines are asynchronous to the system clock. Each passes through a two-stage synchroniser, and the serial clock is oversampled. The `WORD_BITS` parameter sets the word length: 28 gives four port-select bits, and 26 gives the reduced variant with two port-select bits.

Top module: `tuner_serial_ctl`

## Requirements
- R1: After reset, every control output is zero.
- R2: Bit positions of the accepted word, with bit 0 as the last bit shifted in: drive_off = bit 0, test_en = bit 1, cp_hi = bit 2, ref_sel = bits 5:3, presc_en = bit 6, div_ratio = bits 23:7, port_sel = bits WORD_BITS-1:24. Bits are sampled on rising serial-clock edges, most significant bit first.
- R3: The control outputs change only in the cycle after a div_tick pulse, and only when a word is pending. A pulse with nothing pending leaves them unchanged.
- R4: If the number of bits received before enable falls differs from WORD_BITS, whether fewer or more, the word is discarded and the outputs keep their values.
- R5: Serial-clock edges that occur while enable is low shift no data and count no bits.
- R6: A word accepted while an earlier word is still pending replaces the earlier word. The next div_tick applies only the newer word.
- R7: With WORD_BITS = 26, a 26-bit word is accepted, port_sel is 2 bits wide, and all other fields keep the positions given in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Serial enable, asynchronous |
| div_tick | input | 1 | One-cycle divider cycle-boundary pulse |
| port_sel | output | WORD_BITS-24 | Port select outputs |
| div_ratio | output | 17 | Programmable divider ratio |
| presc_en | output | 1 | Prescaler enable |
| ref_sel | output | 3 | Reference-divider ratio select |
| cp_hi | output | 1 | Charge-pump current select |
| test_en | output | 1 | Test mode enable |
| drive_off | output | 1 | Varactor drive disable |

## Verification
The hardest condition to reach is a second word that arrives while the first is still pending. The bench reaches it by sending two complete frames back to back without any div_tick pulse. It then shows that a single pulse applies only the second frame.

Gating of stray serial-clock edges while enable is low cannot be seen directly at the outputs. The bench therefore toggles the serial clock while enable is low and then sends a frame of exactly the right length. If those stray edges were counted, the frame would be discarded, and that shows up at the outputs. A 26-bit instance shares the serial lines with the 28-bit one, so each frame is a length mismatch for one of the two instances.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int DIV_BITS   = 17;
    localparam int FIXED_BITS = 24;

    typedef struct packed {
        logic [DIV_BITS-1:0] div_ratio;
        logic                presc_en;
        logic [2:0]          ref_sel;
        logic                cp_hi;
        logic                test_en;
        logic                drive_off;
    } tsc_ctrl_t;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] stab_q, stab_d;

    always_comb begin
        meta_d = async_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/tsc_shifter.sv
module tsc_shifter #(
    parameter int WORD_BITS = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sdat_i,
    input  logic                 sen_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 load_o
);
    localparam int CW = $clog2(WORD_BITS + 2);
    localparam logic [CW-1:0] FULL = CW'(WORD_BITS);
    localparam logic [CW-1:0] OVER = CW'(WORD_BITS + 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    typedef struct packed {
        logic                 clk_prev;
        logic                 en_prev;
        logic [CW-1:0]        cnt;
        logic [WORD_BITS-1:0] sh;
        logic                 load;
        logic [WORD_BITS-1:0] word;
    } shift_st_t;

    shift_st_t st_q, st_d;

    always_comb begin
        st_d          = st_q;
        st_d.load     = 1'b0;
        st_d.clk_prev = sclk_i;
        st_d.en_prev  = sen_i;
        if (sen_i && sclk_i && !st_q.clk_prev) begin
            st_d.sh = {st_q.sh[WORD_BITS-2:0], sdat_i};
            if (st_q.cnt != OVER) begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
        if (st_q.en_prev && !sen_i) begin
            if (st_q.cnt == FULL) begin
                st_d.load = 1'b1;
                st_d.word = st_q.sh;
            end
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;
    assign load_o = st_q.load;

    p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= OVER);

    p_load_en_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |-> !st_q.en_prev);

    p_no_shift_en_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_i |=> $stable(st_q.sh));
endmodule

// File: rtl/tsc_commit.sv
module tsc_commit #(
    parameter int WORD_BITS = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [WORD_BITS-1:0] word_i,
    input  logic                 tick_i,
    output logic [WORD_BITS-1:0] active_o
);
    typedef struct packed {
        logic                 pend;
        logic [WORD_BITS-1:0] hold;
        logic [WORD_BITS-1:0] active;
    } commit_st_t;

    commit_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tick_i && st_q.pend) begin
            st_d.active = st_q.hold;
            st_d.pend   = 1'b0;
        end
        if (load_i) begin
            st_d.hold = word_i;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    p_active_waits_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && st_q.pend) |=> $stable(active_o));

    p_load_sets_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.pend && st_q.hold == $past(word_i));

    p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.pend && !load_i) |=> !st_q.pend);
endmodule

// File: rtl/tuner_serial_ctl.sv
module tuner_serial_ctl #(
    parameter int WORD_BITS = 28,
    localparam int PORT_BITS = WORD_BITS - tsc_pkg::FIXED_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_en,
    input  logic                 div_tick,
    output logic [PORT_BITS-1:0] port_sel,
    output logic [16:0]          div_ratio,
    output logic                 presc_en,
    output logic [2:0]           ref_sel,
    output logic                 cp_hi,
    output logic                 test_en,
    output logic                 drive_off
);
    import tsc_pkg::*;

    logic [2:0]           sync_w;
    logic [WORD_BITS-1:0] word_w;
    logic                 load_w;
    logic [WORD_BITS-1:0] active_w;
    tsc_ctrl_t            ctrl_w;

    initial begin
        assert (WORD_BITS > FIXED_BITS)
            else $error("WORD_BITS must exceed the fixed field width");
    end

    tsc_sync #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en, ser_clk, ser_dat}),
        .sync_o  (sync_w)
    );

    tsc_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sync_w[1]),
        .sdat_i (sync_w[0]),
        .sen_i  (sync_w[2]),
        .word_o (word_w),
        .load_o (load_w)
    );

    tsc_commit #(.WORD_BITS(WORD_BITS)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .word_i   (word_w),
        .tick_i   (div_tick),
        .active_o (active_w)
    );

    always_comb begin
        ctrl_w = tsc_ctrl_t'(active_w[FIXED_BITS-1:0]);
    end

    assign port_sel  = active_w[WORD_BITS-1:FIXED_BITS];
    assign div_ratio = ctrl_w.div_ratio;
    assign presc_en  = ctrl_w.presc_en;
    assign ref_sel   = ctrl_w.ref_sel;
    assign cp_hi     = ctrl_w.cp_hi;
    assign test_en   = ctrl_w.test_en;
    assign drive_off = ctrl_w.drive_off;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (active_w == '0));
endmodule

// File: tb/tuner_serial_ctl_tb.sv
module tuner_serial_ctl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0, div_tick = 1'b0;
    int checks = 0, errors = 0;

    logic [3:0]  wp;  logic [16:0] wd; logic wde; logic [2:0] wr; logic wc, wt, wo;
    logic [1:0]  np;  logic [16:0] nd; logic nde; logic [2:0] nr; logic nc, nt, no;

    always #4 clk = ~clk;

    tuner_serial_ctl #(.WORD_BITS(28)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .div_tick(div_tick), .port_sel(wp), .div_ratio(wd), .presc_en(wde), .ref_sel(wr),
        .cp_hi(wc), .test_en(wt), .drive_off(wo));

    tuner_serial_ctl #(.WORD_BITS(26)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .div_tick(div_tick), .port_sel(np), .div_ratio(nd), .presc_en(nde), .ref_sel(nr),
        .cp_hi(nc), .test_en(nt), .drive_off(no));

    function automatic logic [23:0] low24(logic [16:0] d, logic de, logic [2:0] r,
                                          logic c, logic t, logic o);
        return {d, de, r, c, t, o};
    endfunction

    function automatic logic [27:0] wide_obs();
        return {wp, wd, wde, wr, wc, wt, wo};
    endfunction

    function automatic logic [25:0] narrow_obs();
        return {np, nd, nde, nr, nc, nt, no};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [31:0] val, int nbits);
        ser_en = 1'b1;
        wait_cyc(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = val[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(4);
        ser_en = 1'b0;
        wait_cyc(8);
    endtask

    task automatic tick();
        div_tick = 1'b1;
        wait_cyc(1);
        div_tick = 1'b0;
        wait_cyc(3);
    endtask

    task automatic t_reset();
        chk("R1 wide reset", 32'(wide_obs()), 32'd0);
        chk("R1 narrow reset", 32'(narrow_obs()), 32'd0);
    endtask

    task automatic t_basic_wide();
        logic [27:0] w = {4'hA, low24(17'h12345, 1'b1, 3'b101, 1'b1, 1'b0, 1'b1)};
        send_bits(32'(w), 28);
        chk("R3 no change before tick", 32'(wide_obs()), 32'd0);
        tick();
        chk("R2 wide fields", 32'(wide_obs()), 32'(w));
        chk("R2 div_ratio", 32'(wd), 32'h12345);
        chk("R2 ref_sel", 32'(wr), 32'd5);
        chk("R4 narrow drops 28-bit", 32'(narrow_obs()), 32'd0);
    endtask

    task automatic t_narrow();
        logic [25:0] w = {2'b10, low24(17'h0ABCD, 1'b0, 3'b011, 1'b0, 1'b1, 1'b0)};
        logic [27:0] keep = wide_obs();
        send_bits(32'(w), 26);
        tick();
        chk("R7 narrow fields", 32'(narrow_obs()), 32'(w));
        chk("R7 narrow port_sel", 32'(np), 32'd2);
        chk("R4 wide drops 26-bit", 32'(wide_obs()), 32'(keep));
    endtask

    task automatic t_bad_length();
        logic [27:0] kw = wide_obs();
        logic [25:0] kn = narrow_obs();
        send_bits(32'h0FFF_FFFF, 27);
        tick();
        chk("R4 short wide", 32'(wide_obs()), 32'(kw));
        send_bits(32'h1555_5555, 29);
        tick();
        chk("R4 long wide", 32'(wide_obs()), 32'(kw));
        chk("R4 long narrow", 32'(narrow_obs()), 32'(kn));
    endtask

    task automatic t_en_low();
        logic [27:0] w = {4'h5, low24(17'h1F0F0, 1'b1, 3'b110, 1'b0, 1'b1, 1'b1)};
        ser_dat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_cyc(4); ser_clk = 1'b1;
            wait_cyc(4); ser_clk = 1'b0;
        end
        wait_cyc(4);
        send_bits(32'(w), 28);
        tick();
        chk("R5 edges with enable low ignored", 32'(wide_obs()), 32'(w));
    endtask

    task automatic t_replace();
        logic [27:0] a = {4'h3, low24(17'h00111, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0)};
        logic [27:0] b = {4'hC, low24(17'h1ACE1, 1'b1, 3'b010, 1'b0, 1'b0, 1'b1)};
        send_bits(32'(a), 28);
        send_bits(32'(b), 28);
        tick();
        chk("R6 newer word wins", 32'(wide_obs()), 32'(b));
        tick();
        chk("R3 idle tick no change", 32'(wide_obs()), 32'(b));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_basic_wide();
        t_narrow();
        t_bad_length();
        t_en_low();
        t_replace();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule